// File: doc/BRIEF.md
# Asynchronous Serial Port with Break Handling

This block is a full-duplex asynchronous serial port for byte traffic. A transmit holding register feeds a shift register. A one-cycle `baudTick` input paces both directions at sixteen ticks per bit. The receiver samples each bit at its centre, checks the stop bit and an optional parity bit, and keeps running while the line is held low. Because of this, a sustained break shows up again as a fresh framing error on every frame slot. A standby bit sets the whole port to a halted state out of reset, and software must clear it before anything except the control register responds.

The transmit pin can be removed from the serial function and driven by two port bits, a level and a direction. The level bit resets to the mark state. Software sends a break by clearing the level bit and then turning the direction to output. Software reaches the port through a four-entry register bus. The status register has flags that are cleared by writing zero after reading them as one.

Top module: `async_serial_port`

## Requirements
- R1: Register addresses: 0 transmit holding, 1 receive data, 2 status, 3 control. The control register resets to 0x41. Its bits, from bit 0 upward, are: standby, tx enable, rx enable, parity enable, odd parity, pin serial select, port level, port direction. While standby is 1, writes to addresses 0 to 2 are ignored, reads of addresses 0 to 2 return 0, and neither shifter runs.
- R2: Status bit 7 (transmit empty) resets to 1. A write to address 0 clears it. It returns to 1 in the cycle the holding byte moves into the idle shift register.
- R3: A write to address 0 is accepted whatever the state of bit 7. When bit 7 is 0, the new byte replaces the held byte, and the replaced byte is never transmitted.
- R4: A frame is a 0 start bit, then 8 data bits LSB first, then a parity bit if enabled, then a 1 stop bit. Each bit lasts 16 ticks. Even parity sends the XOR of the data bits; odd parity sends its complement.
- R5: Status bit 2 (transmit end) reads 1 when bit 7 is 1 and the shifter is idle. The serial-driven pin then rests at 1.
- R6: The receiver samples each bit at its eighth tick. A frame with a good stop bit and good parity is loaded into address 1 and sets status bit 6 (receive full).
- R7: A good frame that completes while bit 6 is 1 sets status bit 5 (overrun), and address 1 keeps its old byte.
- R8: A 0 stop bit sets status bit 4 (framing). A parity mismatch sets status bit 3. A frame with either error is not loaded and does not set bit 6.
- R9: The receiver keeps running through a held-low line. A framing flag cleared during a break is set again at the next frame's stop check.
- R10: Bits 6 to 3 clear only when written 0 after a status read that returned them as 1. A hardware set in the same cycle as the clear wins.
- R11: With pin serial select 0, the pin drives the port level bit when the port direction bit is 1, and rests at 1 when it is 0. The pin therefore idles at 1 out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous-style reset, sampled on the clock |
| baudTick | input | 1 | One-cycle pulse, sixteen per bit |
| addr | input | 2 | Register select |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe; read data is valid in the same cycle |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, 0 when rdEn is low |
| rxd | input | 1 | Serial input, synchronised inside |
| txd | output | 1 | Serial or port-driven output pin |

## Verification
The assertions assume the following about the inputs. `baudTick` is a single-cycle pulse. The frame format bits change only while both shifters are idle. A status write never lands in the same cycle as a status read. The bench respects these limits: it produces one tick every four clocks from a fixed divider, it changes the parity setting only between completed frames, and its bus tasks issue a single read or a single write per transaction.

// File: rtl/sport_pkg.sv
package sport_pkg;
  localparam int DATA_W  = 8;
  localparam int OVS     = 16;
  localparam int MID     = OVS / 2;
  localparam int TICK_W  = $clog2(OVS);
  localparam int FRAME_W = DATA_W + 3;
  localparam int BIT_W   = $clog2(FRAME_W + 1);
  localparam int FLAG_N  = 4;
  localparam logic [1:0] ADDR_TX   = 2'd0;
  localparam logic [1:0] ADDR_RX   = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam logic [1:0] ADDR_CTRL = 2'd3;
  localparam logic [7:0] CTRL_RESET = 8'h41;

  typedef struct packed {
    logic              halt;
    logic              txLoad;
    logic [DATA_W-1:0] txByte;
    logic              parEn;
    logic              parOdd;
    logic              rxRun;
  } ctrlStrobe_t;

  typedef struct packed {
    logic              txIdle;
    logic              txLine;
    logic              rxDone;
    logic [DATA_W-1:0] rxByte;
    logic              frameErr;
    logic              parErr;
  } dpReport_t;
endpackage

// File: rtl/sport_dp.sv
module sport_dp
  import sport_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        baudTick,
  input  logic        rxdIn,
  input  ctrlStrobe_t strobe,
  output dpReport_t   report
);
  // transmit shifter
  logic [FRAME_W-1:0] txFrame;
  logic [BIT_W-1:0]   txBitsLeft;
  logic [TICK_W-1:0]  txTick;
  logic               txParBit;

  assign txParBit = (^strobe.txByte) ^ strobe.parOdd;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.halt) begin
      txFrame    <= '1;
      txBitsLeft <= '0;
      txTick     <= '0;
    end else if (strobe.txLoad) begin
      txTick <= '0;
      if (strobe.parEn) begin
        txFrame    <= {1'b1, txParBit, strobe.txByte, 1'b0};
        txBitsLeft <= BIT_W'(FRAME_W);
      end else begin
        txFrame    <= {2'b11, strobe.txByte, 1'b0};
        txBitsLeft <= BIT_W'(FRAME_W - 1);
      end
    end else if (txBitsLeft != '0 && baudTick) begin
      if (txTick == TICK_W'(OVS - 1)) begin
        txTick     <= '0;
        txFrame    <= {1'b1, txFrame[FRAME_W-1:1]};
        txBitsLeft <= txBitsLeft - 1'b1;
      end else begin
        txTick <= txTick + 1'b1;
      end
    end
  end

  // receive shifter
  logic              rxMeta, rxSync, rxActive, rxParBit;
  logic              rxDoneQ, rxFeQ, rxPeQ;
  logic [TICK_W-1:0] rxTick;
  logic [BIT_W-1:0]  rxIdx, rxLastIdx;
  logic [DATA_W-1:0] rxShift;

  assign rxLastIdx = strobe.parEn ? BIT_W'(DATA_W + 2) : BIT_W'(DATA_W + 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxMeta   <= 1'b1;
      rxSync   <= 1'b1;
      rxActive <= 1'b0;
      rxTick   <= '0;
      rxIdx    <= '0;
      rxShift  <= '0;
      rxParBit <= 1'b0;
      rxDoneQ  <= 1'b0;
      rxFeQ    <= 1'b0;
      rxPeQ    <= 1'b0;
    end else begin
      rxMeta  <= rxdIn;
      rxSync  <= rxMeta;
      rxDoneQ <= 1'b0;
      if (strobe.halt || !strobe.rxRun) begin
        rxActive <= 1'b0;
        rxTick   <= '0;
        rxIdx    <= '0;
      end else if (baudTick) begin
        if (!rxActive) begin
          if (!rxSync) begin
            rxActive <= 1'b1;
            rxTick   <= '0;
            rxIdx    <= '0;
          end
        end else begin
          rxTick <= (rxTick == TICK_W'(OVS - 1)) ? '0 : rxTick + 1'b1;
          if (rxTick == TICK_W'(MID - 1)) begin
            rxIdx <= rxIdx + 1'b1;
            if (rxIdx == '0) begin
              if (rxSync) rxActive <= 1'b0;
            end else if (rxIdx <= BIT_W'(DATA_W)) begin
              rxShift <= {rxSync, rxShift[DATA_W-1:1]};
            end else if (rxIdx == rxLastIdx) begin
              rxDoneQ  <= 1'b1;
              rxFeQ    <= !rxSync;
              rxPeQ    <= strobe.parEn && (rxParBit != ((^rxShift) ^ strobe.parOdd));
              rxActive <= 1'b0;
            end else begin
              rxParBit <= rxSync;
            end
          end
        end
      end
    end
  end

  assign report.txIdle   = (txBitsLeft == '0);
  assign report.txLine   = (txBitsLeft != '0) ? txFrame[0] : 1'b1;
  assign report.rxDone   = rxDoneQ;
  assign report.rxByte   = rxShift;
  assign report.frameErr = rxFeQ;
  assign report.parErr   = rxPeQ;

  // a freshly loaded frame starts with the low start bit
  assert_start_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.txLoad && !strobe.halt |=> !report.txLine && !report.txIdle);

  // the receive bit index never runs past the stop position
  assert_rx_index_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    rxActive |-> rxIdx <= BIT_W'(DATA_W + 2));

  // a done pulse always closes the active frame
  assert_done_closes_R9: assert property (@(posedge clk) disable iff (!rstN)
    rxDoneQ |-> !rxActive);
endmodule

// File: rtl/sport_ctrl.sv
module sport_ctrl
  import sport_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  dpReport_t         report,
  output ctrlStrobe_t       strobe,
  output logic              txd
);
  logic [7:0] ctrlReg;
  logic standby, txEn, rxEn, parEn, parOdd, pinSer, portLevel, portDir;
  assign {portDir, portLevel, pinSer, parOdd, parEn, rxEn, txEn, standby} = ctrlReg;

  logic [DATA_W-1:0] txBuf, rxBuf;
  logic              txEmpty, txEnd;
  logic              txWr, statWr, statRd, goodFrame;
  logic [FLAG_N-1:0] flagQ, hwSet;   // {rxFull, overrun, framing, parity}

  assign txWr      = wrEn && addr == ADDR_TX && !standby;
  assign statWr    = wrEn && addr == ADDR_STAT && !standby;
  assign statRd    = rdEn && addr == ADDR_STAT && !standby;
  assign goodFrame = report.rxDone && !report.frameErr && !report.parErr;

  assign hwSet = {goodFrame && !flagQ[3], goodFrame && flagQ[3],
                  report.rxDone && report.frameErr, report.rxDone && report.parErr};

  always_ff @(posedge clk) begin
    if (!rstN) ctrlReg <= CTRL_RESET;
    else if (wrEn && addr == ADDR_CTRL) ctrlReg <= wrData[7:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txBuf   <= '0;
      txEmpty <= 1'b1;
    end else if (txWr) begin
      txBuf   <= wrData;
      txEmpty <= 1'b0;
    end else if (strobe.txLoad) begin
      txEmpty <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rxBuf <= '0;
    else if (goodFrame && !flagQ[3]) rxBuf <= report.rxByte;
  end

  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    logic flagBit, armedBit;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        flagBit  <= 1'b0;
        armedBit <= 1'b0;
      end else begin
        if (hwSet[i]) flagBit <= 1'b1;
        else if (statWr && armedBit && !wrData[i+3]) flagBit <= 1'b0;
        if (!flagBit) armedBit <= 1'b0;
        else if (statRd) armedBit <= 1'b1;
      end
    end
    assign flagQ[i] = flagBit;
  end

  assign txEnd = txEmpty && report.txIdle;

  assign strobe.halt   = standby;
  assign strobe.txLoad = !standby && txEn && !txEmpty && report.txIdle;
  assign strobe.txByte = txBuf;
  assign strobe.parEn  = parEn;
  assign strobe.parOdd = parOdd;
  assign strobe.rxRun  = !standby && rxEn;

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      case (addr)
        ADDR_CTRL: rdData = ctrlReg;
        ADDR_TX:   rdData = standby ? '0 : txBuf;
        ADDR_RX:   rdData = standby ? '0 : rxBuf;
        default:   rdData = standby ? '0 : {txEmpty, flagQ, txEnd, 2'b00};
      endcase
    end
  end

  assign txd = pinSer ? (standby ? 1'b1 : report.txLine)
                      : (portDir ? portLevel : 1'b1);

  assert_standby_ignores_R1: assert property (@(posedge clk) disable iff (!rstN)
    standby && wrEn && addr == ADDR_TX |=> $stable(txBuf));

  assert_transfer_sets_empty_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.txLoad && !txWr |=> txEmpty);

  assert_overrun_keeps_R7: assert property (@(posedge clk) disable iff (!rstN)
    goodFrame && flagQ[3] |=> $stable(rxBuf) && flagQ[2]);

  assert_error_not_loaded_R8: assert property (@(posedge clk) disable iff (!rstN)
    report.rxDone && report.frameErr && !flagQ[3] |=> !flagQ[3]);

  assert_hw_set_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    report.rxDone && report.frameErr |=> flagQ[1]);
endmodule

// File: rtl/async_serial_port.sv
module async_serial_port
  import sport_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic [1:0]        addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              rxd,
  output logic              txd
);
  ctrlStrobe_t strobe;
  dpReport_t   report;

  sport_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .report(report), .strobe(strobe), .txd(txd)
  );

  sport_dp u_dp (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .rxdIn(rxd),
    .strobe(strobe), .report(report)
  );
endmodule

// File: tb/sim_async_serial_port.sv
module sim_async_serial_port;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baudTick = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       txd;
  logic       forceLow = 1'b0;
  logic       rxd;
  logic [1:0] divCnt = 2'd0;
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  assign rxd = forceLow ? 1'b0 : txd;

  async_serial_port u0 (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .addr(addr), .wrEn(wrEn),
    .rdEn(rdEn), .wrData(wrData), .rdData(rdData), .rxd(rxd), .txd(txd)
  );

  always #2 clk = ~clk;

  always @(negedge clk) begin
    divCnt   = divCnt + 2'd1;
    baudTick = (divCnt == 2'd3);
  end

  // {parity enable, odd, data byte}
  localparam logic [9:0] VEC [6] = '{
    {2'b00, 8'h55}, {2'b10, 8'hA3}, {2'b11, 8'h00},
    {2'b10, 8'hFF}, {2'b11, 8'h81}, {2'b00, 8'h3C}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic waitFlag(input logic [7:0] mask, input string req);
    logic [7:0] s;
    bit ok;
    ok = 1'b0;
    s = 8'h00;
    for (int n = 0; n < 3000 && !ok; n++) begin
      busRead(2'd2, s);
      if ((s & mask) != 8'h00) ok = 1'b1;
    end
    check(ok, req, s, mask);
  endtask

  function automatic logic [7:0] ctrlVal(input logic pe, input logic odd);
    return {1'b0, 1'b1, 1'b1, odd, pe, 1'b1, 1'b1, 1'b0};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic [7:0] s;
    logic [7:0] d;
    logic pe, odd, expBit;
    repeat (5) @(negedge clk);
    rstN = 1'b1;

    // reset and standby
    check(txd === 1'b1, "R11 pin idles at mark after reset", txd, 1);
    busRead(2'd3, r); check(r == 8'h41, "R1 control reset value", r, 8'h41);
    busRead(2'd2, r); check(r == 8'h00, "R1 status hidden in standby", r, 0);
    busWrite(2'd3, 8'h67);
    busWrite(2'd0, 8'h5A);
    repeat (200) @(negedge clk);
    check(txd === 1'b1, "R1 halted port sends nothing", txd, 1);
    busWrite(2'd3, 8'h66);
    busRead(2'd0, r); check(r == 8'h00, "R1 standby write ignored", r, 0);
    busRead(2'd2, r); check(r == 8'h84, "R2 R5 status after standby exit", r, 8'h84);
    repeat (200) @(negedge clk);
    check(txd === 1'b1, "R1 no frame from ignored write", txd, 1);

    // vector table: frame shape, loopback receive, transmit end
    foreach (VEC[k]) begin
      pe = VEC[k][9]; odd = VEC[k][8]; d = VEC[k][7:0];
      busWrite(2'd3, ctrlVal(pe, odd));
      busWrite(2'd0, d);
      @(negedge txd);
      repeat (32) @(negedge clk);
      for (int b = 0; b < (pe ? 11 : 10); b++) begin
        if (b == 0) expBit = 1'b0;
        else if (b <= 8) expBit = d[b-1];
        else if (b == 9 && pe) expBit = (^d) ^ odd;
        else expBit = 1'b1;
        check(txd === expBit, "R4 frame bit level", txd, expBit);
        if (b < (pe ? 10 : 9)) repeat (64) @(negedge clk);
      end
      waitFlag(8'h40, "R6 receive full");
      busRead(2'd1, r); check(r == d, "R6 received byte", r, d);
      busRead(2'd2, s); check((s & 8'h38) == 8'h00, "R8 no error flags on good frame", s, 0);
      busWrite(2'd2, 8'hBF);
      repeat (40) @(negedge clk);
      busRead(2'd2, s); check(s == 8'h84, "R5 transmit end after frame", s, 8'h84);
      check(txd === 1'b1, "R5 pin at mark when done", txd, 1);
    end

    // overwrite loss
    busWrite(2'd3, ctrlVal(1'b0, 1'b0));
    busWrite(2'd0, 8'h11);
    busRead(2'd2, s); check(s[7] == 1'b1 && s[2] == 1'b0, "R2 empty after transfer, shifter busy", s, 8'h80);
    busWrite(2'd0, 8'h22);
    busRead(2'd2, s); check(s[7] == 1'b0, "R2 empty cleared by write", s, 0);
    busWrite(2'd0, 8'h33);
    busRead(2'd2, s); check(s[7] == 1'b0, "R3 overwrite accepted while full", s, 0);
    waitFlag(8'h40, "R3 first frame");
    busRead(2'd1, r); check(r == 8'h11, "R3 first byte", r, 8'h11);
    busWrite(2'd2, 8'hBF);
    waitFlag(8'h40, "R3 second frame");
    busRead(2'd1, r); check(r == 8'h33, "R3 replaced byte sent, old lost", r, 8'h33);
    busWrite(2'd2, 8'hBF);
    repeat (1500) @(negedge clk);
    busRead(2'd2, s); check(s == 8'h84, "R3 no third frame", s, 8'h84);

    // overrun
    busWrite(2'd0, 8'h44);
    waitFlag(8'h40, "R7 first byte arrives");
    busWrite(2'd0, 8'h66);
    waitFlag(8'h04, "R7 second frame ends");
    busRead(2'd2, s); check((s & 8'h60) == 8'h60, "R7 overrun and full set", s, 8'h60);
    busRead(2'd1, r); check(r == 8'h44, "R7 old byte kept", r, 8'h44);
    busWrite(2'd2, 8'h00);
    busRead(2'd2, s); check(s == 8'h84, "R10 read-then-write-0 clears", s, 8'h84);

    // sustained break on the line, odd parity
    busWrite(2'd3, ctrlVal(1'b1, 1'b1));
    forceLow = 1'b1;
    repeat (1600) @(negedge clk);
    busWrite(2'd2, 8'h00);
    busRead(2'd2, s);
    check(s[4] == 1'b1, "R10 unread flag survives write 0", s, 8'h10);
    check(s[3] == 1'b1, "R8 parity error in break", s, 8'h08);
    check(s[6] == 1'b0, "R8 errored frame not loaded", s, 0);
    busWrite(2'd2, 8'h00);
    waitFlag(8'h10, "R9 framing re-asserts");
    busWrite(2'd2, 8'h00);
    busRead(2'd2, s); check(s[4] == 1'b0, "R10 framing cleared", s, 0);
    repeat (800) @(negedge clk);
    busRead(2'd2, s); check(s[4] == 1'b1, "R9 framing set again during break", s, 8'h10);
    forceLow = 1'b0;
    repeat (2000) @(negedge clk);
    busRead(2'd2, s);
    busWrite(2'd2, 8'h00);
    busRead(2'd2, s); check(s == 8'h84, "R10 flags cleared after break", s, 8'h84);

    // break through the port path
    busWrite(2'd3, 8'h86);
    check(txd === 1'b0, "R11 port drives level 0", txd, 0);
    waitFlag(8'h10, "R9 port break gives framing error");
    busWrite(2'd3, 8'h06);
    check(txd === 1'b1, "R11 port input rests at mark", txd, 1);
    busWrite(2'd3, 8'hC6);
    check(txd === 1'b1, "R11 port drives level 1", txd, 1);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule